// File: doc/BRIEF.md
# Calendar Alarm Comparator

This unit watches a running real-time calendar, whose second, minute, hour, weekday, day, month and year counts arrive as BCD values from an external counter chain, and compares them every cycle against a set of programmed alarm fields. Software programs the fields through a simple byte-wide write port. Each field has its own enable bit, and only enabled fields take part in the comparison. When every enabled field equals its counter, the unit raises a sticky alarm flag. An interrupt line follows the flag, gated by an interrupt-enable bit.

The flag is set only in the cycle after the match first becomes true, so a match that lasts a whole second does not keep setting it again. Software clears the flag by writing 0 to its status bit. Writing 1 leaves it alone, which lets other status bits in the same byte be acknowledged without disturbing it. The year field is 8 bits wide and needs its whole byte, so its enable sits in a separate register.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset the alarm flag and the interrupt output are 0, and every field enable, the year enable and the interrupt enable are 0.
- R2: Writes to addresses 0 to 5 load the second, minute, hour, weekday, day and month alarm fields, in that order. Bit 7 of the written byte is the field's enable. The value is the low bits of the byte, cut to the counter's width: second 7, minute 7, hour 7 (PM in bit 6), weekday 3, day 6, month 5.
- R3: A write to address 6 loads the 8-bit BCD year alarm value. Bit 7 of a write to address 7 is the year enable.
- R4: When at least one field is enabled and every enabled field equals its counter, the flag becomes 1 one clock after that match begins. A disabled field never prevents a match.
- R5: The flag is set only on the rising edge of the match. Once cleared, it stays 0 while the same match continues.
- R6: With no field enabled, the flag is never set, whatever the counter and field values.
- R7: A write to address 8 with bit 0 = 0 clears the flag. With bit 0 = 1 the flag is left unchanged. A new match edge in the same cycle as a clear wins, and the flag ends at 1.
- R8: Bit 0 of a write to address 9 is the alarm interrupt enable. The interrupt output equals the flag AND that enable.
- R9: Writes to addresses 10 to 15 change no field, enable, flag or interrupt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the register port |
| wrAddr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| cntSec | input | 7 | Current BCD seconds |
| cntMin | input | 7 | Current BCD minutes |
| cntHour | input | 7 | Current BCD hour, PM in bit 6 |
| cntWday | input | 3 | Current weekday |
| cntDay | input | 6 | Current BCD day of month |
| cntMonth | input | 5 | Current BCD month |
| cntYear | input | 8 | Current BCD year |
| alarmFlag | output | 1 | Sticky alarm status |
| alarmIrq | output | 1 | Alarm interrupt (flag AND enable) |

## Verification
The hardest case to reach is a new match edge arriving in the same clock as a software clear. The bench creates it by setting the year alarm against a mismatching year count, then, on one falling edge, moving the count onto the alarm while also driving a status write with bit 0 = 0. After the next rising edge the flag must read 1. A second hard case is a match that lasts after a clear. The bench keeps the counters still for several cycles after the clear and checks that the flag stays 0. It then forces the match to fall and rise again to show that a new edge still sets the flag.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int FIELD_MAX_W = 7;
  localparam int YEAR_W = 8;

  localparam int ADDR_YEAR = 6;
  localparam int ADDR_YEAR_EN = 7;
  localparam int ADDR_STATUS = 8;
  localparam int ADDR_CTRL = 9;

  // Bit width of each byte-wide alarm field, indexed by its address.
  function automatic int fieldWidth(input int idx);
    case (idx)
      0: return 7;  // second
      1: return 7;  // minute
      2: return 7;  // hour with PM bit
      3: return 3;  // weekday
      4: return 6;  // day
      default: return 5;  // month
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_FIELDS-1:0] loadField;
    logic loadYear;
    logic loadYearEn;
    logic loadCtrl;
    logic clearFlag;
  } strobes_t;
endpackage

// File: rtl/alarm_match_dp.sv
module alarm_match_dp
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               stb,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [FIELD_MAX_W-1:0] cntField [NUM_FIELDS],
  input  logic [YEAR_W-1:0]      cntYear,
  output logic                   matchNow
);
  localparam int EN_BIT = DATA_W - 1;

  logic [NUM_FIELDS-1:0] fieldEn;
  logic [NUM_FIELDS-1:0] fieldEq;
  logic [YEAR_W-1:0] yearVal;
  logic yearEn;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    localparam int W = fieldWidth(i);
    logic [W-1:0] val;
    logic en;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        val <= '0;
        en <= 1'b0;
      end else if (stb.loadField[i]) begin
        val <= wrData[W-1:0];
        en <= wrData[EN_BIT];
      end
    end
    assign fieldEn[i] = en;
    assign fieldEq[i] = (val == cntField[i][W-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yearVal <= '0;
      yearEn <= 1'b0;
    end else begin
      if (stb.loadYear) yearVal <= wrData[YEAR_W-1:0];
      if (stb.loadYearEn) yearEn <= wrData[EN_BIT];
    end
  end

  logic anyEn;
  logic allHit;
  always_comb begin
    anyEn = yearEn | (|fieldEn);
    allHit = (~yearEn | (yearVal == cntYear)) & (&(~fieldEn | fieldEq));
    matchNow = anyEn & allHit;
  end

  // R2: the decoder never asserts two register loads at once
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R3: the year enable follows bit 7 of its write
  a_r3_year_en_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadYearEn |=> (yearEn == $past(wrData[EN_BIT])));
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrBit0,
  input  logic              matchNow,
  output strobes_t          stb,
  output logic              alarmFlag,
  output logic              alarmIrq
);
  logic matchPrev;
  logic irqEn;
  logic setEvt;

  always_comb begin
    stb = '0;
    if (wrEn) begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (wrAddr == ADDR_W'(i)) stb.loadField[i] = 1'b1;
      stb.loadYear = (wrAddr == ADDR_W'(ADDR_YEAR));
      stb.loadYearEn = (wrAddr == ADDR_W'(ADDR_YEAR_EN));
      stb.loadCtrl = (wrAddr == ADDR_W'(ADDR_CTRL));
      stb.clearFlag = (wrAddr == ADDR_W'(ADDR_STATUS)) && !wrBit0;
    end
  end

  assign setEvt = matchNow & ~matchPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchPrev <= 1'b0;
      alarmFlag <= 1'b0;
      irqEn <= 1'b0;
    end else begin
      matchPrev <= matchNow;
      if (setEvt) alarmFlag <= 1'b1;
      else if (stb.clearFlag) alarmFlag <= 1'b0;
      if (stb.loadCtrl) irqEn <= wrBit0;
    end
  end

  assign alarmIrq = alarmFlag & irqEn;

  // R4: a newly set flag always traces back to a comparator match
  a_r4_set_from_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(matchNow));

  // R7: without a clear request the flag is sticky
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !stb.clearFlag) |=> alarmFlag);

  // R8: the interrupt never fires without a pending flag
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> alarmFlag);

  // R5: a match that lasts does not set the flag again
  a_r5_no_refire: assert property (@(posedge clk) disable iff (!rstN)
    (!alarmFlag && matchPrev && matchNow) |=> !alarmFlag);
endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [6:0]        cntSec,
  input  logic [6:0]        cntMin,
  input  logic [6:0]        cntHour,
  input  logic [2:0]        cntWday,
  input  logic [5:0]        cntDay,
  input  logic [4:0]        cntMonth,
  input  logic [7:0]        cntYear,
  output logic              alarmFlag,
  output logic              alarmIrq
);
  strobes_t stb;
  logic matchNow;
  logic [FIELD_MAX_W-1:0] cntField [NUM_FIELDS];

  assign cntField[0] = cntSec;
  assign cntField[1] = cntMin;
  assign cntField[2] = cntHour;
  assign cntField[3] = {4'b0, cntWday};
  assign cntField[4] = {1'b0, cntDay};
  assign cntField[5] = {2'b0, cntMonth};

  alarm_flag_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrBit0(wrData[0]),
    .matchNow(matchNow), .stb(stb), .alarmFlag(alarmFlag), .alarmIrq(alarmIrq)
  );

  alarm_match_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .cntField(cntField), .cntYear(cntYear), .matchNow(matchNow)
  );
endmodule

// File: tb/cal_alarm_top_tb_top.sv
module cal_alarm_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [6:0] cntSec = 7'h30, cntMin = 7'h15, cntHour = 7'h08;
  logic [2:0] cntWday = 3'd3;
  logic [5:0] cntDay = 6'h12;
  logic [4:0] cntMonth = 5'h06;
  logic [7:0] cntYear = 8'h24;
  logic alarmFlag, alarmIrq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cal_alarm_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntSec(cntSec), .cntMin(cntMin), .cntHour(cntHour), .cntWday(cntWday),
    .cntDay(cntDay), .cntMonth(cntMonth), .cntYear(cntYear),
    .alarmFlag(alarmFlag), .alarmIrq(alarmIrq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clearFlag();
    busWrite(4'd8, 8'h00);
  endtask

  task automatic testReset();
    check("R1 flag after reset", alarmFlag, 1'b0);
    check("R1 irq after reset", alarmIrq, 1'b0);
    cntSec = 7'h00; tick(); cntSec = 7'h30; tick();
    check("R1 all enables clear", alarmFlag, 1'b0);
  endtask

  task automatic testMatch();
    busWrite(4'd0, 8'hB1);
    busWrite(4'd1, 8'h95);
    tick();
    check("R4 partial match no flag", alarmFlag, 1'b0);
    cntSec = 7'h31;
    tick();
    check("R4 full match sets flag", alarmFlag, 1'b1);
    check("R8 irq off while disabled", alarmIrq, 1'b0);
  endtask

  task automatic testIrqEnable();
    busWrite(4'd9, 8'h01);
    check("R8 irq with enable", alarmIrq, 1'b1);
    busWrite(4'd9, 8'h00);
    check("R8 irq masked", alarmIrq, 1'b0);
    check("R8 flag kept when masked", alarmFlag, 1'b1);
    busWrite(4'd9, 8'h01);
  endtask

  task automatic testClearAndHold();
    busWrite(4'd8, 8'hFF);
    check("R7 write one keeps flag", alarmFlag, 1'b1);
    clearFlag();
    check("R7 write zero clears flag", alarmFlag, 1'b0);
    check("R8 irq drops with flag", alarmIrq, 1'b0);
    repeat (4) tick();
    check("R5 lasting match no refire", alarmFlag, 1'b0);
  endtask

  task automatic testDisabledField();
    busWrite(4'd2, 8'h15);
    cntSec = 7'h32; tick();
    cntSec = 7'h31; tick();
    check("R4 disabled hour ignored", alarmFlag, 1'b1);
    clearFlag();
  endtask

  task automatic testFieldMask();
    busWrite(4'd0, 8'h31);
    busWrite(4'd1, 8'h15);
    busWrite(4'd3, 8'h8B);
    tick();
    check("R2 weekday masked to 3 bits", alarmFlag, 1'b1);
    clearFlag();
    busWrite(4'd3, 8'h03);
  endtask

  task automatic testNoneEnabled();
    clearFlag();
    busWrite(4'd0, 8'h31);
    cntSec = 7'h00; tick(); tick();
    cntSec = 7'h31; tick(); tick();
    check("R6 no enabled field no flag", alarmFlag, 1'b0);
  endtask

  task automatic testYear();
    busWrite(4'd6, 8'h24);
    busWrite(4'd7, 8'h80);
    tick();
    check("R3 year alarm fires", alarmFlag, 1'b1);
    clearFlag();
    cntYear = 8'h25; tick(); tick();
    check("R3 year mismatch no flag", alarmFlag, 1'b0);
    cntYear = 8'h24; tick();
    check("R3 year match again", alarmFlag, 1'b1);
  endtask

  task automatic testSetBeatsClear();
    cntYear = 8'h25; tick();
    clearFlag();
    check("R7 flag cleared before race", alarmFlag, 1'b0);
    @(negedge clk);
    cntYear = 8'h24; wrEn = 1'b1; wrAddr = 4'd8; wrData = 8'h00;
    @(negedge clk);
    wrEn = 1'b0;
    check("R7 set wins over clear", alarmFlag, 1'b1);
  endtask

  task automatic testUnusedAddr();
    busWrite(4'd12, 8'h00);
    busWrite(4'd15, 8'h00);
    busWrite(4'd10, 8'h99);
    check("R9 flag unaffected", alarmFlag, 1'b1);
    check("R9 irq enable unaffected", alarmIrq, 1'b1);
    cntYear = 8'h25; tick();
    clearFlag();
    cntYear = 8'h24; tick();
    check("R9 year alarm unaffected", alarmFlag, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    testReset();
    testMatch();
    testIrqEnable();
    testClearAndHold();
    testDisabledField();
    testFieldMask();
    testNoneEnabled();
    testYear();
    testSetBeatsClear();
    testUnusedAddr();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule